// File: doc/BRIEF.md
# UART Receive Error Status Tracker

This block sits between a UART deserializer and the bus side of a receiver. Each received character arrives with three error flags: parity error, framing error and break. The block stores characters and flags in a receive FIFO. It keeps a running count of the stored characters that carry any error. From that count it derives a FIFO-level error status. That status decides whether the block raises a receive DMA request or an error interrupt.

The error status stays set while any flagged character remains in the FIFO. Reading the status byte does not clear it. While it is set and DMA requests are enabled, the block raises the error interrupt in place of the DMA request. The request comes back by itself once the last flagged character has been popped. A three-state gating machine makes this choice each cycle. `GATE_IDLE` raises nothing. `GATE_REQ` raises the DMA request. `GATE_ERR` raises the error interrupt. The next state depends only on the DMA enable, the error status and whether the fill level has reached the trigger: the error status selects `GATE_ERR`, otherwise reaching the trigger selects `GATE_REQ`, otherwise `GATE_IDLE`, and a cleared DMA enable always selects `GATE_IDLE`. Any state may move to any other in one clock.

The block also reports transmitter status from two occupancy inputs, and it presents everything as an 8-bit status byte.

Top module: `uart_rx_status`

## Requirements
- R1: With `fifo_mode`=0, status bit 7 (FIFO error) reads 0 whatever flags are stored. The FIFO holds one character, and the trigger level is 1.
- R2: With `fifo_mode`=1, status bit 7 is 1 exactly when at least one stored character has a nonzero flag. It changes in the cycle after the push or pop edge that changes that condition.
- R3: Asserting `lsr_rd` does not clear status bit 7. Bit 7 clears only when the last flagged character has been popped.
- R4: With `dma_en`=1 and status bit 7 set, `err_irq` is 1 and `rx_dma_req` is 0 one clock later, even when the fill level is at or above the trigger.
- R5: After the flagged characters are drained, `rx_dma_req` returns with no further input once the level is at or above the trigger.
- R6: With `dma_en`=0, both `err_irq` and `rx_dma_req` are 0 one clock later, even with bit 7 set.
- R7: With `dma_en`=1 and bit 7 clear, `rx_dma_req` is 1 one clock after the level is at or above the trigger, and 0 otherwise. `trig_sel` selects the trigger: 0 selects 1, 1 selects 8, 2 selects 16, 3 selects 32.
- R8: Status bit 6 is 1 only when both `tx_hold_busy` and `tx_shift_busy` are 0. Status bit 5 is the inverse of `tx_hold_busy`.
- R9: After reset, with the transmit inputs idle, the status byte is 0x60, and `rx_dma_req` and `err_irq` are 0.
- R10: A push and a pop in the same cycle update the FIFO and the error count together, and bit 7 stays correct for every flag combination of the pushed and the popped character.
- R11: A push into a full FIFO with no pop in the same cycle is dropped and sets status bit 1 (overrun). Bit 1 clears on the edge at which `lsr_rd` is 1, unless a new overrun happens on that same edge, in which case bit 1 stays set. A push together with a pop into a full FIFO is accepted.
- R12: Status bit 0 is 1 when the FIFO is non-empty. Bits 4, 3 and 2 show the break, framing and parity flags of the oldest character, and `pop_data` shows its data.
- R13: A pop on an empty FIFO has no effect on level, error status or pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Deserializer offers a character |
| push_data | input | 8 | Received character |
| push_perr | input | 1 | Parity error flag of the character |
| push_ferr | input | 1 | Framing error flag of the character |
| push_brk | input | 1 | Break flag of the character |
| pop | input | 1 | Remove the oldest character |
| pop_data | output | 8 | Data of the oldest character |
| fifo_mode | input | 1 | 1 = 64-deep FIFO, 0 = single holding entry |
| dma_en | input | 1 | Receive DMA requests enabled |
| trig_sel | input | 2 | Trigger level select |
| tx_hold_busy | input | 1 | Transmit holding register or FIFO holds data |
| tx_shift_busy | input | 1 | Transmit shift register holds data |
| lsr_rd | input | 1 | Status byte is being read |
| lsr_data | output | 8 | Status byte |
| rx_dma_req | output | 1 | Receive DMA request |
| err_irq | output | 1 | Receive error interrupt |

## Verification
The status byte and `pop_data` come from registered FIFO state, so they are due in the cycle after the push or pop edge. `rx_dma_req` and `err_irq` come from the gating state register, so they follow the level, error status and enable one more edge later. The bench keeps a model of the FIFO queue, the overrun flag and the gating state. On each edge it computes the request and interrupt from the values before that edge, and it applies the push and pop afterwards. Inputs change on the falling edge, and all outputs are compared on the next falling edge. Each output is therefore checked in the cycle it is due.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_flags_t;

    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_REQ  = 2'd1,
        GATE_ERR  = 2'd2
    } gate_state_e;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  rx_flags_t         push_flags,
    input  logic              pop_req,
    input  logic              cap_one,
    output logic [DATA_W-1:0] head_data,
    output rx_flags_t         head_flags,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              push_ok,
    output logic              pop_ok
);
    localparam int ENT_W = DATA_W + $bits(rx_flags_t);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = cap_one ? (level != '0) : (level == CNT_W'(DEPTH));
    assign pop_ok  = pop_req && (level != '0);
    assign push_ok = push_req && (!full || pop_ok);

    assign {head_flags, head_data} = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= {push_flags, push_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/rxs_errcnt.sv
module rxs_errcnt
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_ok,
    input  rx_flags_t push_flags,
    input  logic      pop_ok,
    input  rx_flags_t head_flags,
    output logic      any_err
);
    logic [CNT_W-1:0] bad_cnt;
    logic             inc, dec;

    assign inc     = push_ok && (push_flags != '0);
    assign dec     = pop_ok && (head_flags != '0);
    assign any_err = (bad_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   bad_cnt <= bad_cnt + 1'b1;
                2'b01:   bad_cnt <= bad_cnt - 1'b1;
                default: bad_cnt <= bad_cnt;
            endcase
        end
    end

endmodule

// File: rtl/rxs_gate_fsm.sv
module rxs_gate_fsm
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic fifo_err,
    input  logic at_trigger,
    output logic dma_req,
    output logic err_irq
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = GATE_IDLE;
        unique case (state_q)
            GATE_IDLE, GATE_REQ, GATE_ERR: begin
                if (!dma_en)         state_d = GATE_IDLE;
                else if (fifo_err)   state_d = GATE_ERR;
                else if (at_trigger) state_d = GATE_REQ;
                else                 state_d = GATE_IDLE;
            end
            default: state_d = GATE_IDLE;
        endcase
    end

    always_comb begin
        dma_req = 1'b0;
        err_irq = 1'b0;
        unique case (state_q)
            GATE_REQ: dma_req = 1'b1;
            GATE_ERR: err_irq = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import rxs_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_perr,
    input  logic              push_ferr,
    input  logic              push_brk,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              fifo_mode,
    input  logic              dma_en,
    input  logic [1:0]        trig_sel,
    input  logic              tx_hold_busy,
    input  logic              tx_shift_busy,
    input  logic              lsr_rd,
    output logic [7:0]        lsr_data,
    output logic              rx_dma_req,
    output logic              err_irq
);
    rx_flags_t        in_flags, head_flags;
    logic [CNT_W-1:0] level, thr;
    logic             fifo_full, push_ok, pop_ok, any_err, fifo_err, overrun;

    assign in_flags = '{brk: push_brk, ferr: push_ferr, perr: push_perr};

    rxs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (push_valid),
        .push_data  (push_data),
        .push_flags (in_flags),
        .pop_req    (pop),
        .cap_one    (!fifo_mode),
        .head_data  (pop_data),
        .head_flags (head_flags),
        .level      (level),
        .full       (fifo_full),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    rxs_errcnt #(.DEPTH(DEPTH)) u_errcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_ok    (push_ok),
        .push_flags (in_flags),
        .pop_ok     (pop_ok),
        .head_flags (head_flags),
        .any_err    (any_err)
    );

    assign fifo_err = fifo_mode && any_err;
    assign thr      = fifo_mode ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1);

    rxs_gate_fsm u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (dma_en),
        .fifo_err   (fifo_err),
        .at_trigger (level >= thr),
        .dma_req    (rx_dma_req),
        .err_irq    (err_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (push_valid && !push_ok)   overrun <= 1'b1;
        else if (lsr_rd)                   overrun <= 1'b0;
    end

    always_comb begin
        lsr_data    = '0;
        lsr_data[7] = fifo_err;
        lsr_data[6] = !tx_hold_busy && !tx_shift_busy;
        lsr_data[5] = !tx_hold_busy;
        if (level != '0) begin
            lsr_data[4] = head_flags.brk;
            lsr_data[3] = head_flags.ferr;
            lsr_data[2] = head_flags.perr;
            lsr_data[0] = 1'b1;
        end
        lsr_data[1] = overrun;
    end

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       push_valid,
    input logic       pop,
    input logic       fifo_mode,
    input logic       dma_en,
    input logic       lsr_rd,
    input logic       full,
    input logic [7:0] lsr_data,
    input logic       rx_dma_req,
    input logic       err_irq
);
    a_r1_no_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !lsr_data[7]);

    a_r3_read_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && lsr_data[7] && !pop && fifo_mode) |=> (lsr_data[7] || !fifo_mode));

    a_r4_err_gives_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && lsr_data[7]) |=> err_irq);

    a_r4_req_irq_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && err_irq));

    a_r6_irq_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(dma_en));

    a_r7_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> $past(lsr_data[0]));

    a_r11_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !pop) |=> lsr_data[1]);

endmodule

bind uart_rx_status rxs_checker u_rxs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop        (pop),
    .fifo_mode  (fifo_mode),
    .dma_en     (dma_en),
    .lsr_rd     (lsr_rd),
    .full       (fifo_full),
    .lsr_data   (lsr_data),
    .rx_dma_req (rx_dma_req),
    .err_irq    (err_irq)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0, push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0, fifo_mode = 1'b1, dma_en = 1'b0, lsr_rd = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       tx_hold_busy = 1'b0, tx_shift_busy = 1'b0;
    logic [7:0] pop_data, lsr_data;
    logic       rx_dma_req, err_irq;

    int total = 0;
    int bad = 0;
    logic [10:0] q[$];
    logic ovr = 1'b0, e_dma = 1'b0, e_irq = 1'b0;

    always #2 clk = ~clk;

    uart_rx_status i_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
        .pop(pop), .pop_data(pop_data), .fifo_mode(fifo_mode), .dma_en(dma_en),
        .trig_sel(trig_sel), .tx_hold_busy(tx_hold_busy), .tx_shift_busy(tx_shift_busy),
        .lsr_rd(lsr_rd), .lsr_data(lsr_data), .rx_dma_req(rx_dma_req), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic bit model_err();
        foreach (q[i]) if (q[i][10:8] != 3'b0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all(input string tag);
        logic [7:0] e;
        e = '0;
        e[7] = fifo_mode && model_err();
        e[6] = !tx_hold_busy && !tx_shift_busy;
        e[5] = !tx_hold_busy;
        if (q.size() > 0) begin
            e[4:2] = q[0][10:8];
            e[0]   = 1'b1;
            chk(tag, "pop_data", pop_data, q[0][7:0]);
        end
        e[1] = ovr;
        chk(tag, "status", lsr_data, e);
        chk(tag, "dma_req", {7'b0, rx_dma_req}, {7'b0, e_dma});
        chk(tag, "err_irq", {7'b0, err_irq}, {7'b0, e_irq});
    endtask

    // one clock: model state before the edge decides request and interrupt
    task automatic cyc(input string tag);
        int  thr;
        bit  errp, pok, full, puk;
        errp = fifo_mode && model_err();
        thr  = !fifo_mode ? 1 : (trig_sel == 0) ? 1 : (trig_sel == 1) ? 8 : (trig_sel == 2) ? 16 : 32;
        pok  = pop && (q.size() > 0);
        full = q.size() >= (fifo_mode ? 64 : 1);
        puk  = push_valid && (!full || pok);
        @(posedge clk);
        e_dma = dma_en && !errp && (q.size() >= thr);
        e_irq = dma_en && errp;
        if (pok) void'(q.pop_front());
        if (puk) q.push_back({push_brk, push_ferr, push_perr, push_data});
        if (push_valid && !puk) ovr = 1'b1;
        else if (lsr_rd)        ovr = 1'b0;
        @(negedge clk);
        push_valid = 1'b0; pop = 1'b0; lsr_rd = 1'b0;
        check_all(tag);
    endtask

    task automatic push_c(input string tag, input logic [7:0] d, input logic [2:0] f);
        push_valid = 1'b1; push_data = d; {push_brk, push_ferr, push_perr} = f;
        cyc(tag);
    endtask

    task automatic pop_c(input string tag);
        pop = 1'b1;
        cyc(tag);
    endtask

    task automatic drain(input string tag);
        while (q.size() > 0) pop_c(tag);
        cyc(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9", "status", lsr_data, 8'h60);
        chk("R9", "dma_req", {7'b0, rx_dma_req}, 8'h0);
        chk("R9", "err_irq", {7'b0, err_irq}, 8'h0);
        cyc("R9");

        // R7 trigger sweep with clean characters
        dma_en = 1'b1;
        for (int t = 0; t < 4; t++) begin
            trig_sel = 2'(t);
            for (int n = 0; n < 40; n++) push_c("R7", 8'(n * 7 + t), 3'b000);
            cyc("R7");
            drain("R7");
        end

        // R2/R3/R4/R5 error holds, survives reads, drains, request returns
        trig_sel = 2'd0;
        push_c("R2", 8'h11, 3'b000);
        for (int f = 1; f < 8; f++) push_c("R2", 8'(8'h20 + f), 3'(f));
        push_c("R2", 8'h33, 3'b000);
        cyc("R4");
        lsr_rd = 1'b1; cyc("R3");
        lsr_rd = 1'b1; cyc("R3");
        for (int k = 0; k < 8; k++) pop_c("R3");
        cyc("R5");
        cyc("R5");
        drain("R5");

        // R6 errors with requests disabled
        dma_en = 1'b0;
        push_c("R6", 8'h44, 3'b100);
        for (int n = 0; n < 3; n++) cyc("R6");
        dma_en = 1'b1; cyc("R4"); cyc("R4");
        drain("R6");

        // R10 push and pop together over every flag pair
        for (int hf = 0; hf < 8; hf++) begin
            for (int pf = 0; pf < 8; pf++) begin
                push_c("R10", 8'(hf * 8 + pf), 3'(hf));
                push_c("R10", 8'h5A, 3'b000);
                push_valid = 1'b1; pop = 1'b1;
                push_data = 8'(8'hA0 + pf); {push_brk, push_ferr, push_perr} = 3'(pf);
                cyc("R10");
                cyc("R10");
                drain("R10");
            end
        end

        // R11 overflow, read clears, push with pop on full accepted
        trig_sel = 2'd3;
        for (int n = 0; n < 64; n++) push_c("R11", 8'(n), 3'b000);
        push_c("R11", 8'hEE, 3'b001);
        push_c("R11", 8'hEF, 3'b000);
        lsr_rd = 1'b1; cyc("R11");
        push_valid = 1'b1; pop = 1'b1; push_data = 8'hC3; {push_brk, push_ferr, push_perr} = 3'b010;
        cyc("R11");
        push_valid = 1'b1; lsr_rd = 1'b1; push_data = 8'hC4;
        cyc("R11");
        lsr_rd = 1'b1; cyc("R11");
        drain("R12");

        // R13 pops on empty
        for (int n = 0; n < 3; n++) pop_c("R13");
        push_c("R13", 8'h77, 3'b000);
        drain("R13");

        // R1 single-entry mode
        fifo_mode = 1'b0;
        push_c("R1", 8'h81, 3'b111);
        push_c("R1", 8'h82, 3'b000);
        cyc("R1");
        lsr_rd = 1'b1; cyc("R1");
        drain("R1");
        fifo_mode = 1'b1;

        // R8 transmitter status sweep
        for (int b = 0; b < 4; b++) begin
            {tx_hold_busy, tx_shift_busy} = 2'(b);
            cyc("R8");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule